// File: doc/BRIEF.md
# Single-Cycle 64-bit RISC Core

This block is a non-pipelined processor core for a small 64-bit load/store instruction subset. Each instruction is fetched, decoded, executed and retired in one clock cycle. Supported operations are: a doubleword load and a doubleword store, each with a small unsigned displacement; register-to-register add, subtract, OR and AND; a branch taken when a register is zero; and an unconditional PC-relative branch. Instructions are 32 bits wide. Operands come from 32 general registers of 64 bits.

The core holds no memory apart from its program counter. The instruction store, the register file and the data memory all sit outside the block, each behind simple combinational read ports and a write strobe, so each can be exercised on its own.

The instruction store is byte-wide. Four byte lanes are read in parallel at PC, PC+1, PC+2 and PC+3 and assembled little-endian. Data memory is addressed in whole 64-bit words, and the displacement is added directly to the word index. The core makes register 31 read as zero and never writes it. It also bounds data-memory accesses to the populated entries.

Top module: `sc_core64`

## Requirements
- R1: With `rst_n` low at a rising clock edge, the PC becomes 0. While `rst_n` is low, `rf_we` and `dm_we` stay low.
- R2: Lane k of `imem_addr` (bits k*6 +: 6) carries the low 6 bits of PC+k, for k = 0..3. The instruction is `{lane3, lane2, lane1, lane0}`, so the byte at the lowest address is the least significant.
- R3: When bits [31:21] are 10001011000 (add), 11001011000 (subtract), 10101010000 (OR) or 10001010000 (AND), register [4:0] receives register[9:5] op register[20:16], modulo 2^64.
- R4: When bits [31:21] are 11111000010 (load), register [4:0] receives data word (register[9:5] + bits[20:12]). The displacement is a 9-bit unsigned value.
- R5: When bits [31:21] are 11111000000 (store), register [4:0] is written to data word (register[9:5] + bits[20:12]), and no register is written.
- R6: A data-word index of 31 or above makes a load return 0. A store to such an index is dropped, and `dm_we` stays low.
- R7: When bits [31:24] are 10110100, the PC advances by 4 times the sign-extended 19-bit field [23:5] if register [4:0] is zero, and by 4 otherwise. This instruction writes nothing.
- R8: When bits [31:26] are 000101, the PC always advances by 4 times the sign-extended 26-bit field [25:0]. Backward and zero offsets are included.
- R9: Register 31 reads as zero on both operand paths, whatever the register file returns. A write aimed at register 31 is dropped.
- R10: Any other encoding writes no register and no data word, and advances the PC by 4.
- R11: Every instruction other than a taken branch advances the PC by exactly 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pc | output | 64 | Current program counter (byte address) |
| imem_addr | output | 24 | Four 6-bit byte addresses, lane k at bits k*6 +: 6 |
| imem_data | input | 32 | Four bytes returned for the lanes, lane k at bits k*8 +: 8 |
| rf_ra_addr | output | 5 | Register file read port A index (first source) |
| rf_ra_data | input | 64 | Read port A data |
| rf_rb_addr | output | 5 | Read port B index (second source, or store/test register) |
| rf_rb_data | input | 64 | Read port B data |
| rf_we | output | 1 | Register write strobe, taken at the rising edge |
| rf_waddr | output | 5 | Register write index |
| rf_wdata | output | 64 | Register write data |
| dm_addr | output | 5 | Data memory word index |
| dm_rdata | input | 64 | Data memory read word |
| dm_we | output | 1 | Data memory write strobe, taken at the rising edge |
| dm_wdata | output | 64 | Data memory write word |

## Verification
The hardest state to reach is a mismatch between what the external register file holds and what the core must see. Register 31 reads as zero only because the core overrides it. The bench therefore plants a nonzero pattern in its model's entry 31 and then issues a zero-test branch, an add and a load that all name register 31. The branch must be taken, the add must use zero, and the model's entry must remain untouched. Data-word indices at and beyond the populated range are reached from a base register preloaded with 30 plus displacements of 1 and 200, and the whole data model is compared after the dropped stores. Backward branches reach PC values that wrap to earlier instructions, so the sign extension of both offset fields is exercised.

// File: rtl/sc_pkg.sv
// sc_pkg: encodings and decoded-control types shared by the core.
// Assumes the register-form field layout: dest [4:0], src A [9:5], src B [20:16].
package sc_pkg;

    localparam int REG_IDX_W = 5;
    localparam logic [REG_IDX_W-1:0] ZERO_REG = 5'd31;

    localparam logic [10:0] OPC_LOAD  = 11'b11111000010;
    localparam logic [10:0] OPC_STORE = 11'b11111000000;
    localparam logic [10:0] OPC_ADD   = 11'b10001011000;
    localparam logic [10:0] OPC_SUB   = 11'b11001011000;
    localparam logic [10:0] OPC_OR    = 11'b10101010000;
    localparam logic [10:0] OPC_AND   = 11'b10001010000;
    localparam logic [7:0]  OPC_CBZ   = 8'b10110100;
    localparam logic [5:0]  OPC_JMP   = 6'b000101;

    typedef enum logic [3:0] {
        K_NOP, K_LOAD, K_STORE, K_ARITH, K_CBZ, K_JMP
    } kind_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_OR, ALU_AND
    } alu_e;

    typedef struct packed {
        kind_e                 kind;
        alu_e                  alu_op;
        logic [REG_IDX_W-1:0]  dst;
        logic [REG_IDX_W-1:0]  src_a;
        logic [REG_IDX_W-1:0]  src_b;
        logic [8:0]            disp;
        logic [25:0]           br_raw;
    } ctl_t;

endpackage

// File: rtl/sc_fetch.sv
// sc_fetch: program counter, byte-lane fetch addressing and next-PC selection.
// Assumes a combinational byte-wide instruction store with one read per lane;
// the instruction is assembled little-endian from LANES consecutive bytes.
module sc_fetch #(
    parameter int XLEN  = 64,
    parameter int ILEN  = 32,
    parameter int IA_W  = 6,
    localparam int LANES = ILEN / 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take_br,
    input  logic                  br_wide,
    input  logic [25:0]           br_raw,
    output logic [XLEN-1:0]       pc_o,
    output logic [LANES*IA_W-1:0] lane_addr,
    input  logic [ILEN-1:0]       lane_byte,
    output logic [ILEN-1:0]       instr_o
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] br_ofs;
    logic [XLEN-1:0] pc_next;

    // One address and one byte slot per lane; lowest address is least significant.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_addr[k*IA_W +: IA_W] = pc_q[IA_W-1:0] + IA_W'(k);
        assign instr_o[k*8 +: 8]         = lane_byte[k*8 +: 8];
    end

    // Sign-extend whichever offset field the branch uses, in instruction units.
    always_comb begin
        if (br_wide) begin
            br_ofs = {{(XLEN-26){br_raw[25]}}, br_raw};
        end else begin
            br_ofs = {{(XLEN-19){br_raw[18]}}, br_raw[18:0]};
        end
    end

    // Choose the sequential or branch successor.
    assign pc_next = take_br ? (pc_q + (br_ofs << 2)) : (pc_q + XLEN'(LANES));

    // Program counter register with synchronous reset to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

    // R11: without a taken branch the PC moves by one instruction.
    a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        !take_br |=> pc_q == $past(pc_q) + XLEN'(LANES));

endmodule

// File: rtl/sc_decode.sv
// sc_decode: classifies an instruction and extracts its fields.
// Assumes 11-bit opcodes are matched before the shorter branch opcodes;
// anything unmatched decodes as a no-op.
module sc_decode
    import sc_pkg::*;
#(
    parameter int ILEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output ctl_t            ctl
);

    logic [10:0] op11;
    logic [7:0]  op8;
    logic [5:0]  op6;

    assign op11 = instr[31:21];
    assign op8  = instr[31:24];
    assign op6  = instr[31:26];

    // Field extraction and opcode classification.
    always_comb begin
        ctl.kind   = K_NOP;
        ctl.alu_op = ALU_ADD;
        ctl.dst    = instr[4:0];
        ctl.src_a  = instr[9:5];
        ctl.src_b  = instr[20:16];
        ctl.disp   = instr[20:12];
        ctl.br_raw = instr[25:0];
        unique case (op11)
            OPC_LOAD:  ctl.kind = K_LOAD;
            OPC_STORE: ctl.kind = K_STORE;
            OPC_ADD:   begin ctl.kind = K_ARITH; ctl.alu_op = ALU_ADD; end
            OPC_SUB:   begin ctl.kind = K_ARITH; ctl.alu_op = ALU_SUB; end
            OPC_OR:    begin ctl.kind = K_ARITH; ctl.alu_op = ALU_OR;  end
            OPC_AND:   begin ctl.kind = K_ARITH; ctl.alu_op = ALU_AND; end
            default: begin
                if (op8 == OPC_CBZ) begin
                    ctl.kind   = K_CBZ;
                    ctl.br_raw = {7'b0, instr[23:5]};
                end else if (op6 == OPC_JMP) begin
                    ctl.kind = K_JMP;
                end
            end
        endcase
        // Stores and zero tests read their data register on port B.
        if (ctl.kind == K_STORE || ctl.kind == K_CBZ) begin
            ctl.src_b = instr[4:0];
        end
    end

endmodule

// File: rtl/sc_alu.sv
// sc_alu: two-operand integer unit for add, subtract, OR and AND.
// Assumes wrap-around arithmetic; no flags are produced.
module sc_alu
    import sc_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_e            op,
    output logic [XLEN-1:0] y
);

    // Operation select.
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            ALU_AND: y = a & b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/sc_lsu.sv
// sc_lsu: word-index address generation and range guard for data memory.
// Assumes the memory holds DM_DEPTH words; indices at or above it are absent.
module sc_lsu #(
    parameter int XLEN     = 64,
    parameter int DM_DEPTH = 31,
    localparam int DM_AW   = (DM_DEPTH > 1) ? $clog2(DM_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [XLEN-1:0]  base,
    input  logic [8:0]       disp,
    input  logic             do_store,
    output logic [DM_AW-1:0] dm_addr,
    output logic             dm_we,
    input  logic [XLEN-1:0]  dm_rdata,
    output logic [XLEN-1:0]  load_val
);

    logic [XLEN-1:0] index;
    logic            in_range;

    // Index is base plus unsigned displacement, checked against the depth.
    assign index    = base + XLEN'(disp);
    assign in_range = index < XLEN'(DM_DEPTH);
    assign dm_addr  = index[DM_AW-1:0];

    // Writes only for in-range stores outside reset; absent words load zero.
    assign dm_we    = do_store && in_range && rst_n;
    assign load_val = in_range ? dm_rdata : '0;

    // R6: the memory never sees a write strobe for a missing word.
    a_r6_store_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> dm_addr < DM_AW'(DM_DEPTH));

endmodule

// File: rtl/sc_core64.sv
// sc_core64: single-cycle core top; joins fetch, decode, execute and memory access.
// Assumes external combinational read ports for instructions, registers and data,
// with register and data writes taken at the rising edge.
module sc_core64
    import sc_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int ILEN       = 32,
    parameter int IMEM_BYTES = 64,
    parameter int DM_DEPTH   = 31,
    localparam int IA_W      = $clog2(IMEM_BYTES),
    localparam int LANES     = ILEN / 8,
    localparam int DM_AW     = (DM_DEPTH > 1) ? $clog2(DM_DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [XLEN-1:0]       pc,
    output logic [LANES*IA_W-1:0] imem_addr,
    input  logic [ILEN-1:0]       imem_data,
    output logic [REG_IDX_W-1:0]  rf_ra_addr,
    input  logic [XLEN-1:0]       rf_ra_data,
    output logic [REG_IDX_W-1:0]  rf_rb_addr,
    input  logic [XLEN-1:0]       rf_rb_data,
    output logic                  rf_we,
    output logic [REG_IDX_W-1:0]  rf_waddr,
    output logic [XLEN-1:0]       rf_wdata,
    output logic [DM_AW-1:0]      dm_addr,
    input  logic [XLEN-1:0]       dm_rdata,
    output logic                  dm_we,
    output logic [XLEN-1:0]       dm_wdata
);

    logic [ILEN-1:0] instr;
    ctl_t            ctl;
    logic [XLEN-1:0] opa, opb, alu_y, load_val;
    logic            take_br;

    sc_fetch #(.XLEN(XLEN), .ILEN(ILEN), .IA_W(IA_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_br   (take_br),
        .br_wide   (ctl.kind == K_JMP),
        .br_raw    (ctl.br_raw),
        .pc_o      (pc),
        .lane_addr (imem_addr),
        .lane_byte (imem_data),
        .instr_o   (instr)
    );

    sc_decode #(.ILEN(ILEN)) u_decode (
        .instr (instr),
        .ctl   (ctl)
    );

    // Register reads, with the zero register overridden inside the core.
    assign rf_ra_addr = ctl.src_a;
    assign rf_rb_addr = ctl.src_b;
    assign opa = (ctl.src_a == ZERO_REG) ? '0 : rf_ra_data;
    assign opb = (ctl.src_b == ZERO_REG) ? '0 : rf_rb_data;

    sc_alu #(.XLEN(XLEN)) u_alu (
        .a  (opa),
        .b  (opb),
        .op (ctl.alu_op),
        .y  (alu_y)
    );

    sc_lsu #(.XLEN(XLEN), .DM_DEPTH(DM_DEPTH)) u_lsu (
        .clk      (clk),
        .rst_n    (rst_n),
        .base     (opa),
        .disp     (ctl.disp),
        .do_store (ctl.kind == K_STORE),
        .dm_addr  (dm_addr),
        .dm_we    (dm_we),
        .dm_rdata (dm_rdata),
        .load_val (load_val)
    );
    assign dm_wdata = opb;

    // Register writeback: loads and arithmetic only, never the zero register.
    assign rf_waddr = ctl.dst;
    assign rf_wdata = (ctl.kind == K_LOAD) ? load_val : alu_y;
    assign rf_we    = rst_n && (ctl.dst != ZERO_REG)
                      && (ctl.kind == K_LOAD || ctl.kind == K_ARITH);

    // Branch resolution: jumps always, zero tests on port B value.
    assign take_br = (ctl.kind == K_JMP) || (ctl.kind == K_CBZ && opb == '0);

    // R9: the register file is never asked to write register 31.
    a_r9_no_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_waddr != ZERO_REG);

    // R7: a zero test on a nonzero, non-zero-register operand falls through.
    a_r7_cbz_nonzero_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.kind == K_CBZ && rf_rb_addr != ZERO_REG && rf_rb_data != '0)
        |=> pc == $past(pc) + XLEN'(LANES));

    // R10: an unrecognised encoding touches neither the registers nor memory.
    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.kind == K_NOP |-> !rf_we && !dm_we);

    // R5: a store never writes a register.
    a_r5_store_no_rf: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.kind == K_STORE |-> !rf_we);

endmodule

// File: tb/sc_core64_tb.sv
module sc_core64_tb;

    localparam int XLEN = 64;
    localparam int IA_W = 6;
    localparam int DMD  = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [XLEN-1:0] pc;
    logic [4*IA_W-1:0] imem_addr;
    logic [31:0] imem_data;
    logic [4:0] rf_ra_addr, rf_rb_addr, rf_waddr;
    logic [XLEN-1:0] rf_ra_data, rf_rb_data, rf_wdata;
    logic rf_we, dm_we;
    logic [4:0] dm_addr;
    logic [XLEN-1:0] dm_rdata, dm_wdata;

    logic [7:0]      im [64];
    logic [XLEN-1:0] rf [32];
    logic [XLEN-1:0] dm [DMD];
    logic [XLEN-1:0] rf_snap [32];
    logic [XLEN-1:0] dm_snap [DMD];
    int checks = 0;
    int errors = 0;
    int bad_we = 0;
    bit done = 0;

    sc_core64 u_dut (
        .clk(clk), .rst_n(rst_n), .pc(pc),
        .imem_addr(imem_addr), .imem_data(imem_data),
        .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf_ra_data),
        .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf_rb_data),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .dm_addr(dm_addr), .dm_rdata(dm_rdata), .dm_we(dm_we), .dm_wdata(dm_wdata)
    );

    for (genvar k = 0; k < 4; k++) begin : g_im
        assign imem_data[k*8 +: 8] = im[imem_addr[k*IA_W +: IA_W]];
    end
    assign rf_ra_data = rf[rf_ra_addr];
    assign rf_rb_data = rf[rf_rb_addr];
    assign dm_rdata   = (dm_addr < 5'(DMD)) ? dm[dm_addr] : '0;

    always @(posedge clk) begin
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (dm_we) begin
            if (dm_addr < 5'(DMD)) dm[dm_addr] <= dm_wdata;
            else bad_we <= bad_we + 1;
        end
    end

    function automatic logic [31:0] enc_r(logic [10:0] opc, int rd, int rn, int rm);
        return {opc, 5'(rm), 6'b0, 5'(rn), 5'(rd)};
    endfunction
    function automatic logic [31:0] enc_m(logic [10:0] opc, int rt, int rn, int d);
        return {opc, 9'(d), 2'b00, 5'(rn), 5'(rt)};
    endfunction
    function automatic logic [31:0] enc_cbz(int rt, int ofs);
        return {8'b10110100, 19'(ofs), 5'(rt)};
    endfunction
    function automatic logic [31:0] enc_b(int ofs);
        return {6'b000101, 26'(ofs)};
    endfunction

    task automatic chk(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(int addr, logic [31:0] w);
        for (int k = 0; k < 4; k++) im[addr + k] = w[k*8 +: 8];
    endtask

    // Enter reset, refill all models, then release on a falling edge.
    task automatic start();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 64; i++) im[i] = 8'h00;
        for (int i = 0; i < 32; i++) rf[i] = XLEN'(i);
        for (int i = 0; i < DMD; i++) dm[i] = XLEN'(100 * i);
        dm[10] = 64'd1540;
        dm[11] = 64'd2117;
    endtask

    task automatic go();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic snap();
        for (int i = 0; i < 32; i++) rf_snap[i] = rf[i];
        for (int i = 0; i < DMD; i++) dm_snap[i] = dm[i];
    endtask

    function automatic int diffs();
        int n = 0;
        for (int i = 0; i < 32; i++) if (rf[i] !== rf_snap[i]) n++;
        for (int i = 0; i < DMD; i++) if (dm[i] !== dm_snap[i]) n++;
        return n;
    endfunction

    task automatic t_reset();
        start();
        put(0, enc_r(11'b10001011000, 5, 3, 2));
        go();
        chk("R1", "pc after reset", pc, 0);
        chk("R2", "lane addresses at pc 0", XLEN'(imem_addr), XLEN'({6'd3, 6'd2, 6'd1, 6'd0}));
        step();
        chk("R2", "lane addresses at pc 4", XLEN'(imem_addr), XLEN'({6'd7, 6'd6, 6'd5, 6'd4}));
        chk("R11", "pc after one add", pc, 4);
        @(negedge clk); rst_n = 1'b0;
        snap();
        step();
        chk("R1", "pc back to 0 in reset", pc, 0);
        chk("R1", "no writes during reset", XLEN'(diffs()), 0);
    endtask

    task automatic t_alu();
        logic [XLEN-1:0] a = 64'h0F0F_0000_FFFF_1234;
        logic [XLEN-1:0] b = 64'h00FF_00FF_0000_4321;
        start();
        rf[2] = a; rf[3] = b;
        put(0,  enc_r(11'b10001011000, 5, 3, 2));
        put(4,  enc_r(11'b11001011000, 4, 3, 2));
        put(8,  enc_r(11'b10101010000, 6, 2, 3));
        put(12, enc_r(11'b10001010000, 7, 2, 3));
        go();
        repeat (4) step();
        chk("R3", "add", rf[5], b + a);
        chk("R3", "subtract wraps", rf[4], b - a);
        chk("R3", "or", rf[6], a | b);
        chk("R3", "and", rf[7], a & b);
        chk("R11", "pc after four ops", pc, 16);
    endtask

    task automatic t_mem();
        start();
        rf[10] = 10; rf[7] = 3; rf[4] = 77; rf[0] = 0;
        put(0,  enc_m(11'b11111000010, 2, 10, 0));
        put(4,  enc_m(11'b11111000010, 3, 10, 1));
        put(8,  enc_m(11'b11111000000, 4, 7, 1));
        put(12, enc_m(11'b11111000010, 5, 7, 1));
        put(16, enc_m(11'b11111000010, 6, 0, 20));
        go();
        step();
        chk("R4", "load zero displacement", rf[2], 1540);
        step();
        chk("R4", "load displacement 1", rf[3], 2117);
        snap();
        step();
        chk("R5", "store word 4", dm[4], 77);
        chk("R5", "store writes no register", XLEN'(diffs()), 1);
        repeat (2) step();
        chk("R4", "load back stored word", rf[5], 77);
        chk("R4", "load displacement 20", rf[6], 2000);
    endtask

    task automatic t_range();
        start();
        rf[11] = 30; rf[4] = 64'h5555;
        put(0,  enc_m(11'b11111000010, 12, 11, 0));
        put(4,  enc_m(11'b11111000010, 13, 11, 1));
        put(8,  enc_m(11'b11111000000, 4, 11, 1));
        put(12, enc_m(11'b11111000000, 4, 11, 200));
        go();
        repeat (2) step();
        chk("R6", "last word loads", rf[12], 3000);
        chk("R6", "index 31 loads zero", rf[13], 0);
        snap();
        repeat (2) step();
        chk("R6", "out of range stores dropped", XLEN'(diffs()), 0);
        chk("R6", "no strobe beyond depth", XLEN'(bad_we), 0);
        chk("R11", "pc after range ops", pc, 16);
    endtask

    task automatic t_cbz();
        start();
        rf[31] = 64'hDEAD_BEEF;
        put(0,  enc_cbz(1, 2));
        put(4,  enc_cbz(0, 2));
        put(12, enc_cbz(31, -3));
        go();
        snap();
        step();
        chk("R7", "nonzero falls through", pc, 4);
        step();
        chk("R7", "zero register operand taken", pc, 12);
        step();
        chk("R9", "reg31 tests as zero, backward", pc, 0);
        chk("R7", "zero test writes nothing", XLEN'(diffs()), 0);
    endtask

    task automatic t_jump();
        start();
        put(0,  enc_b(3));
        put(12, enc_b(-2));
        put(4,  enc_b(0));
        go();
        step();
        chk("R8", "forward jump", pc, 12);
        step();
        chk("R8", "backward jump", pc, 4);
        step();
        chk("R8", "zero offset holds", pc, 4);
    endtask

    task automatic t_zero_reg();
        start();
        rf[31] = 64'hDEAD_BEEF;
        rf[2] = 64'h1234_5678;
        rf[10] = 10;
        put(0, enc_r(11'b10001011000, 31, 2, 3));
        put(4, enc_r(11'b10001011000, 9, 31, 2));
        put(8, enc_m(11'b11111000010, 31, 10, 0));
        put(12, enc_m(11'b11111000000, 31, 10, 2));
        go();
        repeat (4) step();
        chk("R9", "write to reg31 dropped", rf[31], 64'hDEAD_BEEF);
        chk("R9", "reg31 reads zero on port A", rf[9], 64'h1234_5678);
        chk("R9", "store of reg31 writes zero", dm[12], 0);
    endtask

    task automatic t_nop();
        start();
        put(0, 32'hFFFF_FFFF);
        put(4, 32'h0000_0000);
        put(8, enc_r(11'b10001011001, 5, 3, 2));
        go();
        snap();
        repeat (3) step();
        chk("R10", "unknown encodings change nothing", XLEN'(diffs()), 0);
        chk("R10", "pc after three unknowns", pc, 12);
    endtask

    initial begin
        t_reset();
        t_alu();
        t_mem();
        t_range();
        t_cbz();
        t_jump();
        t_zero_reg();
        t_nop();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule